// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the 16-bit management registers of an Ethernet PHY behind a simple parallel access port. The port carries a register address, write data, a write strobe, a read strobe and registered read data. The serial management framing sits outside this block. The block decodes a sparse 5-bit address space. Each decoded address has an access class:

- stored and writable
- readable but not writable
- write-only
- not implemented

Addresses outside the map read as zero and ignore writes.

The block also tracks link state from a plain `link_up` input. The link-status flag in the basic status register latches low: it drops when the link drops, but it recovers only when software reads that register. A write to the control register with its top bit set does not store the data. Instead it performs a selective soft reset and emits a one-cycle pulse that the surrounding logic uses to restart the link. All ports are plain control and data pins. There is no valid/ready handshake, because each access completes in a fixed number of cycles and cannot be back-pressured.

Top module: `mii_mgmt_regs`

## Requirements
- R1: Only addresses 0–10, 15–21, 26, 29 and 30 are mapped. A read of any other address returns 0x0000. A write to any other address changes no register, including registers whose address differs from it only in upper bits.
- R2: After hard reset the registers read as follows: address 0 = 0x1140, 1 = 0x7949, 2 = 0x0141, 3 = PHY_EXT_ID (default 0x0000), 4 = 0x01E1, 5 = 0x01E0, 9 = 0x1E00, 16 = 0x0068, 17 = 0x0000. The registered read data is 0x0000.
- R3: Addresses 4 and 16 store all 16 written bits and read them back. Address 0 stores the written word when bit 15 of the data is 0.
- R4: Writes to addresses 1, 2, 3, 5, 9, 10 and 17 leave their read value unchanged.
- R5: Address 29 is write-only and always reads 0x0000. Addresses 6, 7, 8, 15, 18, 19, 20, 21, 26 and 30 always read 0x0000, and writes to them have no effect.
- R6: Address 10 always reads 0x3C00.
- R7: A write to address 0 with data bit 15 set has these effects, and the written data is discarded:
  - Address 0 becomes its previous value ANDed with 0x3140, which keeps bits 13, 12, 8 and 6.
  - Address 1 becomes 0x7949.
  - Address 17 is ANDed with 0xE001.
- R8: `soft_rst_o` is high for exactly the one cycle after a soft-reset write (R7) and is low at all other times.
- R9: A rising edge on `link_up` sets bits 11 and 10 of address 17 and bit 5 (negotiation complete) of address 1. It leaves bit 2 (link status) of address 1 unchanged.
- R10: A falling edge on `link_up` clears bits 11 and 10 of address 17 and clears bits 5 and 2 of address 1.
- R11: A read of address 1 returns the latched value. After that read, bit 2 of address 1 takes the value of bit 10 of address 17. Bit 2 never rises without such a read.
- R12: `reg_rdata` changes only on the clock edge that samples `reg_rd` high, and it shows the addressed value from then on. `reg_rd` and `reg_wr` are never high together.
- R13: When a register access and a `link_up` edge fall on the same clock edge, the effect of the access is applied first and the link event second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset, synchronous |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| link_up | input | 1 | Live link state from the line side |
| soft_rst_o | output | 1 | One-cycle pulse on a soft-reset write |

## Verification
The hardest state to reach from the ports is a link-status flag that stays low while the link is up. Reaching it takes a link drop followed by a link rise with no read of address 1 in between. The stimulus toggles `link_up` down and up between reads and then expects the first read to show the flag low and the second to show it high. The second awkward case is a soft-reset write that lands on the same edge as a link rise. The bench drives both in one cycle and expects the link event to take effect on top of the reloaded status.

// File: rtl/mii_regs_pkg.sv
package mii_regs_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // access class per address
  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_RW    = 3'd1,
    ACC_RO    = 3'd2,
    ACC_WO    = 3'd3,
    ACC_UNIMP = 3'd4
  } acc_kind_e;

  // register addresses the logic depends on
  localparam addr_t A_CTRL    = 5'd0;
  localparam addr_t A_STAT    = 5'd1;
  localparam addr_t A_ID      = 5'd2;
  localparam addr_t A_EXTID   = 5'd3;
  localparam addr_t A_ADV     = 5'd4;
  localparam addr_t A_PARTNER = 5'd5;
  localparam addr_t A_GCTRL   = 5'd9;
  localparam addr_t A_GSTAT   = 5'd10;
  localparam addr_t A_SPCTRL  = 5'd16;
  localparam addr_t A_SPSTAT  = 5'd17;

  // control register bit positions
  localparam int CTL_RESET_BIT = 15;
  localparam int CTL_SPD_LSB   = 13;
  localparam int CTL_ANEG_BIT  = 12;
  localparam int CTL_DUPLEX    = 8;
  localparam int CTL_SPD_MSB   = 6;
  localparam word_t CTL_KEEP_MASK = word_t'((1 << CTL_SPD_LSB) | (1 << CTL_ANEG_BIT) |
                                            (1 << CTL_DUPLEX)  | (1 << CTL_SPD_MSB));
  localparam word_t CTL_HARD = word_t'((1 << CTL_ANEG_BIT) | (1 << CTL_DUPLEX) |
                                       (1 << CTL_SPD_MSB));

  // basic status bit positions
  localparam int ST_LINK_BIT    = 2;
  localparam int ST_NEGDONE_BIT = 5;
  localparam word_t ST_HARD     = 16'h7949;

  // specific status bit positions
  localparam int SPST_LIVE_BIT     = 10;
  localparam int SPST_RESOLVED_BIT = 11;
  localparam word_t SPST_LINK_MASK = word_t'((1 << SPST_LIVE_BIT) | (1 << SPST_RESOLVED_BIT));
  localparam word_t SPST_SOFT_KEEP = 16'hE001;

  // fixed read values and writable defaults
  localparam word_t ADV_HARD     = 16'h01E1;
  localparam word_t PARTNER_VAL  = 16'h01E0;
  localparam word_t GCTRL_VAL    = 16'h1E00;
  localparam word_t GSTAT_VAL    = 16'h3C00;
  localparam word_t SPCTRL_HARD  = 16'h0068;

  function automatic acc_kind_e acc_kind(input addr_t a);
    acc_kind_e k;
    case (a)
      5'd0, 5'd4, 5'd16:                          k = ACC_RW;
      5'd1, 5'd2, 5'd3, 5'd5, 5'd9, 5'd10, 5'd17: k = ACC_RO;
      5'd29:                                      k = ACC_WO;
      5'd6, 5'd7, 5'd8, 5'd15, 5'd18, 5'd19,
      5'd20, 5'd21, 5'd26, 5'd30:                 k = ACC_UNIMP;
      default:                                    k = ACC_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/mii_addr_decode.sv
module mii_addr_decode
  import mii_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_ok,
  output logic              rd_ok
);

  acc_kind_e kind;

  always_comb begin
    kind  = acc_kind(addr);
    wr_ok = (kind == ACC_RW);
    rd_ok = (kind == ACC_RW) || (kind == ACC_RO);
  end

endmodule

// File: rtl/mii_rw_bank.sv
module mii_rw_bank
  import mii_regs_pkg::*;
#(
  parameter int                        NUM    = 2,
  parameter logic [NUM*ADDR_W-1:0]     ADDRS  = '0,
  parameter logic [NUM*DATA_W-1:0]     RESETS = '0
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM*DATA_W-1:0] q_flat
);

  for (genvar i = 0; i < NUM; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDRS[i*ADDR_W +: ADDR_W];
    localparam logic [DATA_W-1:0] MY_RST  = RESETS[i*DATA_W +: DATA_W];
    logic [DATA_W-1:0] val_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= MY_RST;
      else if (wr_en && addr == MY_ADDR)
        val_q <= wdata;
    end

    assign q_flat[i*DATA_W +: DATA_W] = val_q;
  end

endmodule

// File: rtl/mii_link_track.sv
module mii_link_track (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  output logic link_rise,
  output logic link_fall
);

  logic link_q;

  always_ff @(posedge clk) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  assign link_rise = link_up & ~link_q;
  assign link_fall = ~link_up & link_q;

endmodule

// File: rtl/mii_ctrl_stat.sv
module mii_ctrl_stat
  import mii_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_rise,
  input  logic              link_fall,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] spst_q,
  output logic              soft_pulse_q
);

  word_t ctrl_n, stat_n, spst_n;
  logic  soft_n;

  // access effects first, link events applied on top of them
  always_comb begin
    ctrl_n = ctrl_q;
    stat_n = stat_q;
    spst_n = spst_q;
    soft_n = 1'b0;

    if (ctrl_wr) begin
      if (wdata[CTL_RESET_BIT]) begin
        ctrl_n = ctrl_q & CTL_KEEP_MASK;
        stat_n = ST_HARD;
        spst_n = spst_q & SPST_SOFT_KEEP;
        soft_n = 1'b1;
      end else begin
        ctrl_n = wdata;
      end
    end

    if (stat_rd)
      stat_n[ST_LINK_BIT] = spst_q[SPST_LIVE_BIT];

    if (link_rise) begin
      spst_n                 = spst_n | SPST_LINK_MASK;
      stat_n[ST_NEGDONE_BIT] = 1'b1;
    end

    if (link_fall) begin
      spst_n                 = spst_n & ~SPST_LINK_MASK;
      stat_n[ST_NEGDONE_BIT] = 1'b0;
      stat_n[ST_LINK_BIT]    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q       <= CTL_HARD;
      stat_q       <= ST_HARD;
      spst_q       <= '0;
      soft_pulse_q <= 1'b0;
    end else begin
      ctrl_q       <= ctrl_n;
      stat_q       <= stat_n;
      spst_q       <= spst_n;
      soft_pulse_q <= soft_n;
    end
  end

endmodule

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs
  import mii_regs_pkg::*;
#(
  parameter logic [15:0] PHY_ID     = 16'h0141,
  parameter logic [15:0] PHY_EXT_ID = 16'h0000
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic                reg_wr,
  input  logic                reg_rd,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                link_up,
  output logic                soft_rst_o
);

  localparam int NUM_RW = 2;
  localparam logic [NUM_RW*ADDR_W-1:0] RW_ADDRS  = {A_SPCTRL, A_ADV};
  localparam logic [NUM_RW*DATA_W-1:0] RW_RESETS = {SPCTRL_HARD, ADV_HARD};

  logic wr_ok, rd_ok;
  logic link_rise, link_fall;
  logic [NUM_RW*DATA_W-1:0] rw_flat;
  word_t ctrl_q, stat_q, spst_q;
  word_t rd_word, rdata_q;

  mii_addr_decode u_dec (
    .addr  (reg_addr),
    .wr_ok (wr_ok),
    .rd_ok (rd_ok)
  );

  mii_rw_bank #(
    .NUM    (NUM_RW),
    .ADDRS  (RW_ADDRS),
    .RESETS (RW_RESETS)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr && wr_ok),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .q_flat (rw_flat)
  );

  mii_link_track u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_up   (link_up),
    .link_rise (link_rise),
    .link_fall (link_fall)
  );

  mii_ctrl_stat u_cs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (reg_wr && wr_ok && reg_addr == A_CTRL),
    .stat_rd      (reg_rd && reg_addr == A_STAT),
    .wdata        (reg_wdata),
    .link_rise    (link_rise),
    .link_fall    (link_fall),
    .ctrl_q       (ctrl_q),
    .stat_q       (stat_q),
    .spst_q       (spst_q),
    .soft_pulse_q (soft_rst_o)
  );

  always_comb begin
    rd_word = '0;
    if (rd_ok) begin
      case (reg_addr)
        A_CTRL:    rd_word = ctrl_q;
        A_STAT:    rd_word = stat_q;
        A_ID:      rd_word = PHY_ID;
        A_EXTID:   rd_word = PHY_EXT_ID;
        A_ADV:     rd_word = rw_flat[0*DATA_W +: DATA_W];
        A_PARTNER: rd_word = PARTNER_VAL;
        A_GCTRL:   rd_word = GCTRL_VAL;
        A_GSTAT:   rd_word = GSTAT_VAL;
        A_SPCTRL:  rd_word = rw_flat[1*DATA_W +: DATA_W];
        A_SPSTAT:  rd_word = spst_q;
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_word;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/mii_mgmt_regs_chk.sv
module mii_mgmt_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_rdata,
  input logic        link_up,
  input logic        soft_rst_o,
  input logic [15:0] stat_q,
  input logic [15:0] spst_q
);

  AST_GSTAT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 5'd10 |=> reg_rdata == 16'h3C00); // R6

  AST_ZERO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !(reg_addr inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd9, 5'd10, 5'd16, 5'd17})
    |=> reg_rdata == 16'h0000); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R12

  AST_NO_RW_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R12

  AST_SOFT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 5'd0 && reg_wdata[15] |=> soft_rst_o); // R8

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(reg_wr && reg_addr == 5'd0 && reg_wdata[15])); // R8

  AST_LINK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |=> stat_q[5] && spst_q[10] && spst_q[11]); // R9

  AST_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |=> !stat_q[5] && !stat_q[2] && !spst_q[10]); // R10

  AST_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[2]) |-> $past(reg_rd && reg_addr == 5'd1)); // R11

endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .link_up    (link_up),
  .soft_rst_o (soft_rst_o),
  .stat_q     (stat_q),
  .spst_q     (spst_q)
);

// File: tb/mii_mgmt_regs_tb.sv
module mii_mgmt_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 45;

  // {write, addr, data (wdata or expected), requirement}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  16'h1140, 4'd2},  // R2
    {1'b0, 5'd1,  16'h7949, 4'd2},  // R2
    {1'b0, 5'd2,  16'h0141, 4'd2},  // R2
    {1'b0, 5'd3,  16'h0000, 4'd2},  // R2
    {1'b0, 5'd4,  16'h01E1, 4'd2},  // R2
    {1'b0, 5'd5,  16'h01E0, 4'd2},  // R2
    {1'b0, 5'd9,  16'h1E00, 4'd2},  // R2
    {1'b0, 5'd10, 16'h3C00, 4'd6},  // R6
    {1'b0, 5'd16, 16'h0068, 4'd2},  // R2
    {1'b0, 5'd17, 16'h0000, 4'd2},  // R2
    {1'b0, 5'd6,  16'h0000, 4'd5},  // R5
    {1'b0, 5'd15, 16'h0000, 4'd5},  // R5
    {1'b0, 5'd26, 16'h0000, 4'd5},  // R5
    {1'b0, 5'd11, 16'h0000, 4'd1},  // R1
    {1'b0, 5'd31, 16'h0000, 4'd1},  // R1
    {1'b1, 5'd4,  16'hABCD, 4'd3},  // R3
    {1'b0, 5'd4,  16'hABCD, 4'd3},  // R3
    {1'b1, 5'd16, 16'h1234, 4'd3},  // R3
    {1'b0, 5'd16, 16'h1234, 4'd3},  // R3
    {1'b1, 5'd20, 16'hFFFF, 4'd5},  // R5
    {1'b1, 5'd24, 16'hFFFF, 4'd1},  // R1
    {1'b0, 5'd4,  16'hABCD, 4'd1},  // R1
    {1'b0, 5'd16, 16'h1234, 4'd1},  // R1
    {1'b1, 5'd2,  16'hFFFF, 4'd4},  // R4
    {1'b0, 5'd2,  16'h0141, 4'd4},  // R4
    {1'b1, 5'd5,  16'hFFFF, 4'd4},  // R4
    {1'b0, 5'd5,  16'h01E0, 4'd4},  // R4
    {1'b1, 5'd9,  16'hFFFF, 4'd4},  // R4
    {1'b0, 5'd9,  16'h1E00, 4'd4},  // R4
    {1'b1, 5'd10, 16'h1111, 4'd6},  // R6
    {1'b0, 5'd10, 16'h3C00, 4'd6},  // R6
    {1'b1, 5'd17, 16'hFFFF, 4'd4},  // R4
    {1'b0, 5'd17, 16'h0000, 4'd4},  // R4
    {1'b1, 5'd1,  16'h0000, 4'd4},  // R4
    {1'b0, 5'd1,  16'h7949, 4'd4},  // R4
    {1'b1, 5'd29, 16'hFFFF, 4'd5},  // R5
    {1'b0, 5'd29, 16'h0000, 4'd5},  // R5
    {1'b1, 5'd7,  16'hFFFF, 4'd5},  // R5
    {1'b0, 5'd7,  16'h0000, 4'd5},  // R5
    {1'b1, 5'd0,  16'h0340, 4'd3},  // R3
    {1'b0, 5'd0,  16'h0340, 4'd3},  // R3
    {1'b1, 5'd3,  16'hFFFF, 4'd4},  // R4
    {1'b0, 5'd3,  16'h0000, 4'd4},  // R4
    {1'b1, 5'd0,  16'h1140, 4'd3},  // R3
    {1'b0, 5'd0,  16'h1140, 4'd3}   // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        link_up = 1'b0;
  logic        soft_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_mgmt_regs u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .link_up    (link_up),
    .soft_rst_o (soft_rst_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R2 rdata in reset", reg_rdata, 16'h0000);
    check("R8 pulse in reset", {15'd0, soft_rst_o}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][25]) begin
        wr(VEC[i][24:20], VEC[i][19:4]);
      end else begin
        rd(VEC[i][24:20], v);
        check($sformatf("R%0d vec %0d", VEC[i][3:0], i), v, VEC[i][19:4]);
      end
    end

    // R12: read data held while idle
    rd(5'd4, v);
    @(negedge clk); @(negedge clk);
    check("R12 rdata held", reg_rdata, 16'hABCD);

    // R9 / R11: latched-low link status
    set_link(1'b1);
    rd(5'd1, v);  check("R9 negdone set, link flag latched", v, 16'h7969);
    rd(5'd1, v);  check("R11 link flag after read", v, 16'h796D);
    rd(5'd17, v); check("R9 specific status link bits", v, 16'h0C00);
    set_link(1'b0);
    rd(5'd1, v);  check("R10 status bits cleared", v, 16'h7949);
    rd(5'd17, v); check("R10 specific link bits cleared", v, 16'h0000);
    set_link(1'b1); set_link(1'b0); set_link(1'b1);
    rd(5'd1, v);  check("R11 latched low across bounce", v, 16'h7969);
    rd(5'd1, v);  check("R11 recovered after read", v, 16'h796D);

    // R7 / R8: soft reset
    wr(5'd0, 16'h3FFF);
    rd(5'd0, v);  check("R3 ctrl store", v, 16'h3FFF);
    wr(5'd0, 16'h8000);
    check("R8 pulse high", {15'd0, soft_rst_o}, 16'h0001);
    @(negedge clk);
    check("R8 pulse one cycle", {15'd0, soft_rst_o}, 16'h0000);
    rd(5'd0, v);  check("R7 ctrl kept bits", v, 16'h3140);
    rd(5'd1, v);  check("R7 status reloaded", v, 16'h7949);
    rd(5'd17, v); check("R7 specific status masked", v, 16'h0000);
    wr(5'd0, 16'h1140);
    check("R8 no pulse on plain write", {15'd0, soft_rst_o}, 16'h0000);

    // R13: soft reset and link rise on the same edge
    set_link(1'b0);
    @(negedge clk);
    reg_addr = 5'd0; reg_wdata = 16'h8000; reg_wr = 1'b1; link_up = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(5'd0, v);  check("R7 ctrl after coincident reset", v, 16'h1140);
    rd(5'd1, v);  check("R13 link event after soft reset", v, 16'h7969);
    rd(5'd17, v); check("R13 link bits after soft reset", v, 16'h0C00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule